// File: doc/BRIEF.md
# Strobed Byte Input Port with Handshake Flags

This block is a single byte-wide input port that works in strobed mode. An external device puts a byte on the port pins and pulses an active-low strobe. On the strobe's falling edge the block stores the byte in a one-byte holding register and raises a buffer-full flag back toward the device. If the interrupt enable is set at that moment, it also raises an interrupt request toward the CPU.

The CPU reads the port by driving its active-low read strobe while the port select is high. The two flags clear on opposite edges of that read pulse. The interrupt request drops when the read strobe falls. Buffer-full drops when the read strobe rises, and only then may the device send the next byte. While buffer-full is high, any further strobe is ignored and the stored byte is kept. The read data output always shows the stored byte, never the live pins.

The strobe, the read strobe and the select come from outside the clock domain. Each passes through a chain of synchronising flip-flops before its edge is detected. Every flag change therefore lands a fixed number of clock cycles after the pin edge that caused it.

Top module: `strobed_in_port`

## Requirements
- R1: After reset, buffer-full and interrupt request are 0 and the read data output is all zeros.
- R2: A 1-to-0 transition of the strobe input while buffer-full is 0 stores the port pins in the holding register, sets buffer-full to 1, and the stored byte appears on the read data output.
- R3: A capture made while the interrupt enable is 1 sets the interrupt request to 1.
- R4: A capture made while the interrupt enable is 0 leaves the interrupt request at 0, while buffer-full still goes to 1.
- R5: A 1-to-0 transition of the read strobe while the select is 1 clears the interrupt request, and buffer-full stays 1 until the read strobe returns high.
- R6: A 0-to-1 transition of the read strobe while the select is 1 clears buffer-full.
- R7: A strobe falling edge that arrives while buffer-full is 1 is ignored: the stored byte, buffer-full and the interrupt request keep their values.
- R8: A read strobe pulse while the select is 0 changes neither flag.
- R9: After a capture, changes on the port pins do not reach the read data output.
- R10: The strobe and read inputs pass through SYNC_STAGES flip-flops. A flag changes on the (SYNC_STAGES+1)-th rising clock edge after the input edge that caused it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_pins | input | DATA_W | Byte presented by the external device |
| dev_stb_n | input | 1 | Active-low strobe from the device; its falling edge captures the pins |
| buf_full | output | 1 | High while the holding register holds an unread byte |
| irq | output | 1 | Interrupt request toward the CPU |
| cpu_rd_n | input | 1 | Active-low CPU read strobe |
| port_sel | input | 1 | High when the CPU is addressing this port |
| irq_en | input | 1 | Interrupt enable, sampled at capture |
| rd_data | output | DATA_W | Stored byte |

## Verification
The bench builds the block with DATA_W of 8 and SYNC_STAGES of 2. With those values the three-edge latency from a pin edge to a flag can be checked on exact cycles, both one cycle early and on time. The byte values used are 0xA5, 0x5A, 0xFF and 0x77. They include all-ones and alternating patterns, so a lost or swapped bit in the holding path shows up on the read data output. The full read sequence is run with the select both low and high, and capture is run with the enable both set and clear. This reaches the overrun case, the split clearing of the two flags, and the masked interrupt.

// File: rtl/sib_pkg.sv
package sib_pkg;
  // Which transition an edge detector reports
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/sib_sync.sv
module sib_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb chain_d[g] = async_i;
    end else begin : g_tail
      always_comb chain_d[g] = chain_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= RST_VAL;
      else        chain_q[g] <= chain_d[g];
    end
  end

  assign sync_o = chain_q[LAST];
endmodule

// File: rtl/sib_edge.sv
module sib_edge
  import sib_pkg::*;
#(
  parameter edge_kind_e KIND    = EDGE_FALL,
  parameter logic       RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic pulse_o
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = level_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= prev_d;
  end

  if (KIND == EDGE_FALL) begin : g_fall
    assign pulse_o = prev_q & ~level_i;
  end else begin : g_rise
    assign pulse_o = ~prev_q & level_i;
  end
endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port
  import sib_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] port_pins,
  input  logic              dev_stb_n,
  output logic              buf_full,
  output logic              irq,
  input  logic              cpu_rd_n,
  input  logic              port_sel,
  input  logic              irq_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned CTL_W = 3;
  // bundle order: {select, read strobe, device strobe}
  localparam logic [CTL_W-1:0] CTL_IDLE = 3'b011;

  logic [CTL_W-1:0] ctl_sync;
  logic             stb_s, rd_s, sel_s;

  sib_sync #(
    .WIDTH  (CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({port_sel, cpu_rd_n, dev_stb_n}),
    .sync_o (ctl_sync)
  );

  assign stb_s = ctl_sync[0];
  assign rd_s  = ctl_sync[1];
  assign sel_s = ctl_sync[2];

  logic stb_fall, rd_fall, rd_rise;

  sib_edge #(.KIND(EDGE_FALL), .RST_VAL(1'b1)) u_stb_fall (
    .clk(clk), .rst_n(rst_n), .level_i(stb_s), .pulse_o(stb_fall)
  );
  sib_edge #(.KIND(EDGE_FALL), .RST_VAL(1'b1)) u_rd_fall (
    .clk(clk), .rst_n(rst_n), .level_i(rd_s), .pulse_o(rd_fall)
  );
  sib_edge #(.KIND(EDGE_RISE), .RST_VAL(1'b1)) u_rd_rise (
    .clk(clk), .rst_n(rst_n), .level_i(rd_s), .pulse_o(rd_rise)
  );

  // Events
  logic capture, rd_lead, rd_trail;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              full_q, full_d;
  logic              irq_q,  irq_d;

  assign capture  = stb_fall & ~full_q;
  assign rd_lead  = rd_fall  & sel_s;
  assign rd_trail = rd_rise  & sel_s;

  // Next-state logic
  always_comb begin
    hold_d = hold_q;
    full_d = full_q;
    irq_d  = irq_q;
    if (capture) begin
      hold_d = port_pins;
      full_d = 1'b1;
      irq_d  = irq_en;
    end else begin
      if (rd_lead)  irq_d  = 1'b0;
      if (rd_trail) full_d = 1'b0;
    end
  end

  // Holding register, clock-enabled by capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (capture) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      irq_q  <= irq_d;
    end
  end

  assign buf_full = full_q;
  assign irq      = irq_q;
  assign rd_data  = hold_q;

  // Assertions
  a_r2_full_rises_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(stb_fall));

  a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(irq_en));

  a_r5_irq_clears_on_read_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(rd_fall && sel_s));

  a_r6_full_clears_on_read_trail: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_q) |-> $past(rd_rise && sel_s));

  a_r7_byte_held_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && stb_fall) |=> $stable(hold_q));

  a_r8_unselected_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_fall || rd_rise) && !sel_s && !stb_fall) |=> ($stable(full_q) && $stable(irq_q)));
endmodule

// File: tb/strobed_in_port_tb.sv
module strobed_in_port_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] port_pins;
  logic          dev_stb_n, cpu_rd_n, port_sel, irq_en;
  logic          buf_full, irq;
  logic [DW-1:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  strobed_in_port #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_pins(port_pins), .dev_stb_n(dev_stb_n),
    .buf_full(buf_full), .irq(irq), .cpu_rd_n(cpu_rd_n), .port_sel(port_sel),
    .irq_en(irq_en), .rd_data(rd_data)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(logic [DW-1:0] b);
    port_pins = b;
    @(negedge clk) dev_stb_n = 1'b0;
    cyc(4);
    dev_stb_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_reset;
    chk("R1 buf_full", buf_full, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_latency_capture;
    irq_en = 1'b1;
    port_pins = 8'hA5;
    @(negedge clk) dev_stb_n = 1'b0;
    cyc(2);
    chk("R10 buf_full not early", buf_full, 0);
    cyc(1);
    chk("R10 buf_full on third edge", buf_full, 1);
    chk("R2 rd_data", rd_data, 8'hA5);
    chk("R3 irq", irq, 1);
    dev_stb_n = 1'b1;
    port_pins = 8'h3C;
    cyc(4);
    chk("R9 rd_data ignores pins", rd_data, 8'hA5);
  endtask

  task automatic t_overrun;
    strobe(8'h77);
    chk("R7 byte kept", rd_data, 8'hA5);
    chk("R7 buf_full kept", buf_full, 1);
    chk("R7 irq kept", irq, 1);
  endtask

  task automatic t_unselected_read;
    port_sel = 1'b0;
    @(negedge clk) cpu_rd_n = 1'b0;
    cyc(5);
    chk("R8 irq after unselected fall", irq, 1);
    cpu_rd_n = 1'b1;
    cyc(5);
    chk("R8 buf_full after unselected rise", buf_full, 1);
  endtask

  task automatic t_read(logic [DW-1:0] exp_b, bit exp_irq);
    chk("R2 byte before read", rd_data, exp_b);
    chk("R3/R4 irq before read", irq, exp_irq);
    port_sel = 1'b1;
    @(negedge clk) cpu_rd_n = 1'b0;
    cyc(2);
    chk("R10 irq not cleared early", irq, exp_irq);
    cyc(1);
    chk("R5 irq cleared on read fall", irq, 0);
    chk("R5 buf_full held during read", buf_full, 1);
    cyc(2);
    cpu_rd_n = 1'b1;
    cyc(2);
    chk("R10 buf_full not cleared early", buf_full, 1);
    cyc(1);
    chk("R6 buf_full cleared on read rise", buf_full, 0);
    port_sel = 1'b0;
    cyc(3);
  endtask

  task automatic t_masked;
    irq_en = 1'b0;
    strobe(8'h5A);
    chk("R4 buf_full", buf_full, 1);
    chk("R4 irq masked", irq, 0);
    chk("R2 rd_data", rd_data, 8'h5A);
    t_read(8'h5A, 1'b0);
  endtask

  task automatic t_ones;
    irq_en = 1'b1;
    strobe(8'hFF);
    chk("R2 rd_data ones", rd_data, 8'hFF);
    chk("R3 irq", irq, 1);
    t_read(8'hFF, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    port_pins = '0;
    dev_stb_n = 1'b1;
    cpu_rd_n = 1'b1;
    port_sel = 1'b0;
    irq_en = 1'b0;
    cyc(3);
    t_reset;
    rst_n = 1'b1;
    cyc(3);
    t_reset;
    t_latency_capture;
    t_overrun;
    t_unselected_read;
    t_read(8'hA5, 1'b1);
    t_masked;
    t_ones;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule